// File: doc/BRIEF.md
# Page Access Density Monitor

The monitor observes the life of every page held in a page-organized cache and records how much of each page is actually used. A page is 2 Kbytes, split into 32 blocks of 64 bytes. For each cache slot the monitor keeps a bitmap with one bit per block. A bit is set when its block is touched during the time the page is resident in that slot.

Events reach the monitor one per cycle on a small event port. Each event is idle, fill, touch or evict, and carries a slot index and a block offset. On an eviction, the monitor counts the distinct blocks that were touched and sorts the page into one of three density classes: fine, other or coarse. It then adds the page to a fetch histogram. If the eviction is marked dirty, it also adds the page to a writeback histogram. All six histogram counters saturate and can be read through a small register port with a one-cycle read latency. An eviction of a slot that holds no page is reported through a sticky error flag.

Top module: `page_density_mon`

## Requirements
- R1: A fill event (ev_kind = 2'b01) makes the slot resident and replaces its bitmap with a single set bit at the block that caused the fill. This holds even if the slot was already resident.
- R2: A touch event (ev_kind = 2'b10) on a resident slot sets bit ev_block of its bitmap. Touching a block that is already set leaves the count unchanged.
- R3: At an eviction (ev_kind = 2'b11) of a resident slot, a page with at most FINE_MAX (8) distinct blocks is classed fine.
- R4: A page with at least COARSE_MIN (24) distinct blocks is classed coarse. A page with a count from 9 to 23 is classed other.
- R5: Every eviction of a resident slot increments the fetch counter of its class. When ev_dirty is 1, the eviction also increments the writeback counter of the same class.
- R6: Each counter holds at its all-ones value instead of wrapping.
- R7: An eviction makes the slot non-resident. A touch on a non-resident slot is ignored. An eviction of a non-resident slot changes no counter and sets err_flag, which stays set until reset.
- R8: rd_data shows, one cycle after rd_addr is presented, the counter that rd_addr selects. rd_addr[2] chooses the bank (0 = fetch, 1 = writeback) and rd_addr[1:0] chooses the class (0 = fine, 1 = other, 2 = coarse). Address 3 within either bank reads 0.
- R9: After reset, all counters read 0, err_flag is 0 and no slot is resident.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_kind | input | 2 | Event: 00 idle, 01 fill, 10 touch, 11 evict |
| ev_slot | input | SLOT_W | Cache slot the event refers to |
| ev_block | input | BLK_W (5) | Block offset within the page |
| ev_dirty | input | 1 | The eviction writes the page back |
| rd_addr | input | 3 | Counter select |
| rd_data | output | CNT_W | Selected counter, registered |
| err_flag | output | 1 | Sticky flag for an eviction of a non-resident slot |

## Verification
Bitmap updates and histogram increments take effect at the same clock edge that samples the event. A touch in the next cycle therefore already sees the bitmap written by a fill, and a read presented in the cycle after an eviction already returns the new count. err_flag is registered and is also high one cycle after the bad eviction. Because rd_data is registered, the bench drives every event and every read address on the falling edge and samples rd_data one full cycle later, on the next falling edge. After each eviction in the sweep, the bench reads all eight addresses and compares each against its own saturating model.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  typedef enum logic [1:0] {
    EV_IDLE  = 2'b00,
    EV_FILL  = 2'b01,
    EV_TOUCH = 2'b10,
    EV_EVICT = 2'b11
  } ev_kind_t;

  typedef enum logic [1:0] {
    CLS_FINE   = 2'd0,
    CLS_OTHER  = 2'd1,
    CLS_COARSE = 2'd2
  } dens_cls_t;
endpackage

// File: rtl/pdm_footprint.sv
module pdm_footprint
  import pdm_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int BLOCKS    = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BLK_W    = $clog2(BLOCKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_kind_t          kind,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BLK_W-1:0]  blk,
  output logic [BLOCKS-1:0] map_o,
  output logic              resident_o
);
  logic [BLOCKS-1:0]    map_mem [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] res_q;
  logic [BLOCKS-1:0]    blk_onehot;

  assign blk_onehot = {{(BLOCKS-1){1'b0}}, 1'b1} << blk;
  assign map_o      = map_mem[slot];
  assign resident_o = res_q[slot];

  // bitmap storage: no reset, single write port per cycle
  always_ff @(posedge clk) begin
    if (kind == EV_FILL)
      map_mem[slot] <= blk_onehot;
    else if (kind == EV_TOUCH && res_q[slot])
      map_mem[slot] <= map_mem[slot] | blk_onehot;
  end

  always_ff @(posedge clk) begin
    if (rst)
      res_q <= '0;
    else if (kind == EV_FILL)
      res_q[slot] <= 1'b1;
    else if (kind == EV_EVICT)
      res_q[slot] <= 1'b0;
  end

  // R1
  fill_makes_resident_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == EV_FILL) |=> res_q[$past(slot)]);
  // R7
  evict_clears_resident_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == EV_EVICT) |=> !res_q[$past(slot)]);
  // R1
  fill_single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (kind == EV_FILL) |=> $onehot0(map_mem[$past(slot)]));
endmodule

// File: rtl/pdm_popcount.sv
module pdm_popcount #(
  parameter int W      = 32,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     bits_i,
  output logic [CNT_W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < W; i++)
      count_o = count_o + CNT_W'(bits_i[i]);
  end
endmodule

// File: rtl/pdm_classify.sv
module pdm_classify
  import pdm_pkg::*;
#(
  parameter int BLOCKS     = 32,
  parameter int FINE_MAX   = 8,
  parameter int COARSE_MIN = 24,
  localparam int CNT_W     = $clog2(BLOCKS + 1)
) (
  input  logic [CNT_W-1:0] count_i,
  output dens_cls_t        cls_o
);
  always_comb begin
    if (count_i <= CNT_W'(FINE_MAX))
      cls_o = CLS_FINE;
    else if (count_i >= CNT_W'(COARSE_MIN))
      cls_o = CLS_COARSE;
    else
      cls_o = CLS_OTHER;
  end
endmodule

// File: rtl/pdm_histogram.sv
module pdm_histogram
  import pdm_pkg::*;
#(
  parameter int CNT_W   = 16,
  localparam int NCLS   = 3,
  localparam int NBANK  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic             dirty_i,
  input  dens_cls_t        cls_i,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] cnt_q [NBANK][NCLS];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar c = 0; c < NCLS; c++) begin : g_cls
      logic bump;
      assign bump = hit_i && (cls_i == dens_cls_t'(c)) && (b == 0 || dirty_i);

      always_ff @(posedge clk) begin
        if (rst)
          cnt_q[b][c] <= '0;
        else if (bump && cnt_q[b][c] != '1)
          cnt_q[b][c] <= cnt_q[b][c] + 1'b1;
      end

      // R6
      no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q[b][c] >= $past(cnt_q[b][c]));
    end
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_pair
    // R5
    wb_within_fetch_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q[1][c] <= cnt_q[0][c]);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_addr[1:0] == 2'd3)
      rd_data <= '0;
    else
      rd_data <= cnt_q[rd_addr[2]][rd_addr[1:0]];
  end

  // R7
  idle_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_i |=> $stable(cnt_q[0][0]) && $stable(cnt_q[0][1]) && $stable(cnt_q[0][2]));
endmodule

// File: rtl/page_density_mon.sv
module page_density_mon
  import pdm_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int BLOCKS     = 32,
  parameter int FINE_MAX   = 8,
  parameter int COARSE_MIN = 24,
  parameter int CNT_W      = 16,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BLK_W     = $clog2(BLOCKS),
  localparam int POP_W     = $clog2(BLOCKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        ev_kind,
  input  logic [SLOT_W-1:0] ev_slot,
  input  logic [BLK_W-1:0]  ev_block,
  input  logic              ev_dirty,
  input  logic [2:0]        rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              err_flag
);
  ev_kind_t          kind;
  logic [BLOCKS-1:0] map;
  logic              resident;
  logic [POP_W-1:0]  pop;
  dens_cls_t         cls;
  logic              evict_ok;
  logic              evict_bad;

  assign kind      = ev_kind_t'(ev_kind);
  assign evict_ok  = (kind == EV_EVICT) && resident;
  assign evict_bad = (kind == EV_EVICT) && !resident;

  pdm_footprint #(.NUM_SLOTS(NUM_SLOTS), .BLOCKS(BLOCKS)) u_fp (
    .clk(clk), .rst(rst), .kind(kind), .slot(ev_slot), .blk(ev_block),
    .map_o(map), .resident_o(resident)
  );

  pdm_popcount #(.W(BLOCKS)) u_pop (.bits_i(map), .count_o(pop));

  pdm_classify #(.BLOCKS(BLOCKS), .FINE_MAX(FINE_MAX), .COARSE_MIN(COARSE_MIN)) u_cls (
    .count_i(pop), .cls_o(cls)
  );

  pdm_histogram #(.CNT_W(CNT_W)) u_hist (
    .clk(clk), .rst(rst), .hit_i(evict_ok), .dirty_i(ev_dirty), .cls_i(cls),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)
      err_flag <= 1'b0;
    else if (evict_bad)
      err_flag <= 1'b1;
  end

  // R7
  bad_evict_flag_chk: assert property (@(posedge clk) disable iff (rst)
    evict_bad |=> err_flag);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R3
  pop_range_chk: assert property (@(posedge clk) disable iff (rst)
    evict_ok |-> (pop >= POP_W'(1)) && (pop <= POP_W'(BLOCKS)));
endmodule

// File: tb/page_density_mon_bench.sv
module page_density_mon_bench;
  localparam int SLOTS = 4;
  localparam int CW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst = 1;
  logic [1:0]    ev_kind = 0;
  logic [1:0]    ev_slot = 0;
  logic [4:0]    ev_block = 0;
  logic          ev_dirty = 0;
  logic [2:0]    rd_addr = 0;
  logic [CW-1:0] rd_data;
  logic          err_flag;

  int checks = 0;
  int errors = 0;
  int exp_cnt [8];
  bit done = 0;

  always #10 clk = ~clk;

  page_density_mon #(.NUM_SLOTS(SLOTS), .CNT_W(CW)) u_page_density_mon (
    .clk(clk), .rst(rst), .ev_kind(ev_kind), .ev_slot(ev_slot),
    .ev_block(ev_block), .ev_dirty(ev_dirty), .rd_addr(rd_addr),
    .rd_data(rd_data), .err_flag(err_flag)
  );

  task automatic ev(input logic [1:0] k, input int s, input int b, input bit d);
    @(negedge clk);
    ev_kind = k; ev_slot = 2'(s); ev_block = 5'(b); ev_dirty = d;
    @(negedge clk);
    ev_kind = 2'b00; ev_dirty = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      rd_addr = 3'(a);
      @(negedge clk);
      chk(req, int'(rd_data), exp_cnt[a]);
    end
  endtask

  task automatic bump(input int idx);
    if (exp_cnt[idx] < CMAX) exp_cnt[idx]++;
  endtask

  function automatic int cls_of(input int n);
    if (n <= 8) return 0;
    if (n >= 24) return 2;
    return 1;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) exp_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R9: reset state
    chk("R9 err", int'(err_flag), 0);
    check_all("R9 R8");

    // sweep of distinct-block counts 1..32: R2 R3 R4 R5 R8
    for (int k = 1; k <= 32; k++) begin
      int s;
      s = k % SLOTS;
      ev(2'b01, s, 0, 0);
      for (int b = 1; b < k; b++) ev(2'b10, s, b, 0);
      ev(2'b10, s, 0, 0);
      ev(2'b10, s, k - 1, 0);
      ev(2'b11, s, 0, k[0]);
      bump(cls_of(k));
      if (k[0]) bump(4 + cls_of(k));
      if (k <= 8) check_all("R3 R2 R5");
      else if (k >= 24) check_all("R4 R2 R5");
      else check_all("R4 other R5");
    end

    // R1: refill of a resident slot restarts its bitmap
    ev(2'b01, 0, 0, 0);
    for (int b = 1; b < 30; b++) ev(2'b10, 0, b, 0);
    ev(2'b01, 0, 7, 0);
    ev(2'b11, 0, 0, 0);
    bump(0);
    check_all("R1");

    // R7: evict of non-resident slot, touches ignored
    chk("R7 err before", int'(err_flag), 0);
    for (int b = 0; b < 32; b++) ev(2'b10, 2, b, 0);
    ev(2'b11, 2, 0, 1);
    chk("R7 err set", int'(err_flag), 1);
    check_all("R7 no count");

    // R6: saturation of fine counters
    for (int i = 0; i < 12; i++) begin
      ev(2'b01, 1, 3, 0);
      ev(2'b11, 1, 0, 1);
      bump(0); bump(4);
    end
    check_all("R6");
    chk("R7 sticky", int'(err_flag), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule